// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block takes a table of interrupt lines and, for each processor it serves, finds the most urgent interrupt that is both enabled and pending for that processor. A smaller priority value means more urgent, and the unsigned value `0x100` stands for "nothing found", since it lies above any 8-bit priority. The winner is reported as that processor's highest-pending ID when it passes the processor's priority mask. It raises the processor's request line only when it is also strictly more urgent than what the processor is running now.

The lowest `NPRIV` interrupt numbers are private: each processor keeps its own priority byte for them. All higher numbers share one priority byte that every processor sees. Enable and pending bits are supplied as one copy per processor. A global distributor enable and a per-processor interface enable both gate the result. Register access, acknowledge and completion are handled elsewhere and feed this block through its plain control inputs. There is no data stream at its edge, so it has no valid/ready handshake. Both outputs are registered and follow any change on the inputs one clock later.

Top module: `irq_prio_select`

## Requirements
- R1: During and directly after reset every request output is 0 and every highest-pending ID reads 1023.
- R2: An interrupt is a candidate for a processor only when both its enable bit and its pending bit for that processor are 1. Bit `c*NIRQ+i` of `irq_en` and `irq_pend` belongs to interrupt i of processor c.
- R3: Among candidates, the one with the numerically smallest priority value wins.
- R4: When candidates tie on priority, the lowest interrupt number wins.
- R5: The highest-pending ID shows the winner only when the winner's priority is less than or equal to that processor's `prio_mask` byte. Otherwise it reads 1023.
- R6: The request output is 1 only when the ID is shown under R5 and the winner's priority is also strictly less than that processor's 9-bit `run_prio` field. A value of 0x100 there means the processor is idle.
- R7: While `dist_en` is 0, every request output is 0 and every ID reads 1023.
- R8: While `cpu_en[c]` is 0, processor c has request 0 and ID 1023, and the other processors are unaffected.
- R9: For interrupt i < NPRIV, processor c uses byte `c*NPRIV+i` of `priv_prio`. For i >= NPRIV, all processors use byte `i-NPRIV` of `shared_prio`.
- R10: Outputs change on the first rising clock edge after an input change and hold their value before that edge.
- R11: With no candidate at all, the ID reads 1023 and the request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dist_en | input | 1 | Global distributor enable |
| cpu_en | input | NCPU | Per-processor interface enable |
| irq_en | input | NCPU*NIRQ | Per-processor enable bits |
| irq_pend | input | NCPU*NIRQ | Per-processor pending bits |
| priv_prio | input | NCPU*NPRIV*PW | Per-processor priority bytes for private interrupts |
| shared_prio | input | (NIRQ-NPRIV)*PW | Shared priority bytes for the remaining interrupts |
| prio_mask | input | NCPU*PW | Per-processor priority mask |
| run_prio | input | NCPU*(PW+1) | Per-processor running priority, 0x100 = idle |
| irq_req | output | NCPU | Per-processor interrupt request |
| hp_id | output | NCPU*10 | Per-processor highest-pending ID, 1023 = none |

## Verification
The main function is driven with pairs of candidates. One member of each pair is private and the other shared, and the pairs are placed in different orders. This separates a wrong priority comparison from a wrong tie-break direction and from a mixed-up private/shared lookup. The mask and the running priority are each set exactly equal to the winner's priority and then one step away from it. This separates the inclusive mask test from the strict running test. Directed cases give two processors different private priorities for the same line, and they clear each enable separately. These cases expose results that leak from one processor to another and gating that ignores one of the enables.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;
endpackage

// File: rtl/irqsel_prio_map.sv
module irqsel_prio_map #(
  parameter int NIRQ  = 64,
  parameter int NCPU  = 2,
  parameter int NPRIV = 32,
  parameter int PW    = 8,
  parameter int CPU   = 0
) (
  input  logic [NCPU*NPRIV*PW-1:0]   priv_prio,
  input  logic [(NIRQ-NPRIV)*PW-1:0] shared_prio,
  output logic [NIRQ*PW-1:0]         prio_vec
);
  localparam int PRIV_BASE = CPU * NPRIV * PW;

  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    if (i < NPRIV) begin : g_priv
      assign prio_vec[i*PW +: PW] = priv_prio[PRIV_BASE + i*PW +: PW];
    end else begin : g_shr
      assign prio_vec[i*PW +: PW] = shared_prio[(i-NPRIV)*PW +: PW];
    end
  end
endmodule

// File: rtl/irqsel_pick.sv
module irqsel_pick
  import irqsel_pkg::*;
#(
  parameter int NIRQ = 64,
  parameter int PW   = 8
) (
  input  logic [NIRQ-1:0]    en,
  input  logic [NIRQ-1:0]    pend,
  input  logic [NIRQ*PW-1:0] prio_vec,
  output logic [PW:0]        best_prio,
  output logic [ID_W-1:0]    best_id
);
  // Upward scan with strict less-than: lowest number wins a tie (R4).
  always_comb begin
    best_prio = {1'b1, {PW{1'b0}}};
    best_id   = NONE_ID;
    for (int i = 0; i < NIRQ; i++) begin
      if (en[i] && pend[i] && ({1'b0, prio_vec[i*PW +: PW]} < best_prio)) begin
        best_prio = {1'b0, prio_vec[i*PW +: PW]};
        best_id   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqsel_gate.sv
module irqsel_gate
  import irqsel_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dist_en,
  input  logic            cpu_en,
  input  logic [PW-1:0]   pmask,
  input  logic [PW:0]     run_prio,
  input  logic [PW:0]     best_prio,
  input  logic [ID_W-1:0] best_id,
  output logic            irq_req,
  output logic [ID_W-1:0] hp_id
);
  logic open_q;
  logic pass_mask;
  logic beat_run;

  assign open_q    = dist_en && cpu_en;
  assign pass_mask = best_prio <= {1'b0, pmask};
  assign beat_run  = best_prio < run_prio;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      hp_id   <= NONE_ID;
    end else begin
      irq_req <= open_q && pass_mask && beat_run;
      hp_id   <= (open_q && pass_mask) ? best_id : NONE_ID;
    end
  end

  p_req_has_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (hp_id != NONE_ID));

  p_req_below_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(best_prio) < $past(run_prio)));

  p_id_within_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_id != NONE_ID) |-> ($past(best_prio) <= {1'b0, $past(pmask)}));

  p_dist_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dist_en |=> (!irq_req && hp_id == NONE_ID));

  p_cpu_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |=> (!irq_req && hp_id == NONE_ID));
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irqsel_pkg::*;
#(
  parameter int NIRQ  = 64,
  parameter int NCPU  = 2,
  parameter int NPRIV = 32,
  parameter int PW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dist_en,
  input  logic [NCPU-1:0]            cpu_en,
  input  logic [NCPU*NIRQ-1:0]       irq_en,
  input  logic [NCPU*NIRQ-1:0]       irq_pend,
  input  logic [NCPU*NPRIV*PW-1:0]   priv_prio,
  input  logic [(NIRQ-NPRIV)*PW-1:0] shared_prio,
  input  logic [NCPU*PW-1:0]         prio_mask,
  input  logic [NCPU*(PW+1)-1:0]     run_prio,
  output logic [NCPU-1:0]            irq_req,
  output logic [NCPU*ID_W-1:0]       hp_id
);
  localparam int RW = PW + 1;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NIRQ*PW-1:0] prio_vec;
    logic [PW:0]        best_prio;
    logic [ID_W-1:0]    best_id;

    irqsel_prio_map #(.NIRQ(NIRQ), .NCPU(NCPU), .NPRIV(NPRIV), .PW(PW), .CPU(c)) u_map (
      .priv_prio  (priv_prio),
      .shared_prio(shared_prio),
      .prio_vec   (prio_vec)
    );

    irqsel_pick #(.NIRQ(NIRQ), .PW(PW)) u_pick (
      .en       (irq_en[c*NIRQ +: NIRQ]),
      .pend     (irq_pend[c*NIRQ +: NIRQ]),
      .prio_vec (prio_vec),
      .best_prio(best_prio),
      .best_id  (best_id)
    );

    irqsel_gate #(.PW(PW)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .dist_en  (dist_en),
      .cpu_en   (cpu_en[c]),
      .pmask    (prio_mask[c*PW +: PW]),
      .run_prio (run_prio[c*RW +: RW]),
      .best_prio(best_prio),
      .best_id  (best_id),
      .irq_req  (irq_req[c]),
      .hp_id    (hp_id[c*ID_W +: ID_W])
    );

    // R11: with no candidate the registered ID is the none code.
    p_empty_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en[c*NIRQ +: NIRQ] & irq_pend[c*NIRQ +: NIRQ]) == '0
        |=> (hp_id[c*ID_W +: ID_W] == NONE_ID && !irq_req[c]));
  end
endmodule

// File: tb/irq_prio_select_tb_top.sv
module irq_prio_select_tb_top;
  localparam int NIRQ = 64, NCPU = 2, NPRIV = 32, PW = 8, IDW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic dist_en;
  logic [NCPU-1:0] cpu_en;
  logic [NCPU*NIRQ-1:0] irq_en, irq_pend;
  logic [NCPU*NPRIV*PW-1:0] priv_prio;
  logic [(NIRQ-NPRIV)*PW-1:0] shared_prio;
  logic [NCPU*PW-1:0] prio_mask;
  logic [NCPU*(PW+1)-1:0] run_prio;
  logic [NCPU-1:0] irq_req;
  logic [NCPU*IDW-1:0] hp_id;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_select #(.NIRQ(NIRQ), .NCPU(NCPU), .NPRIV(NPRIV), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
    .irq_en(irq_en), .irq_pend(irq_pend), .priv_prio(priv_prio),
    .shared_prio(shared_prio), .prio_mask(prio_mask), .run_prio(run_prio),
    .irq_req(irq_req), .hp_id(hp_id));

  // idA, pA, idB, pB, mask, run, expected id, expected req (processor 0)
  localparam logic [57:0] VECS [0:7] = '{
    {7'd5,  8'h40, 7'd40, 8'h20, 8'hF0, 9'h100, 10'd40,   1'b1},  // R3
    {7'd10, 8'h30, 7'd50, 8'h30, 8'hF0, 9'h100, 10'd10,   1'b1},  // R4
    {7'd50, 8'h30, 7'd10, 8'h30, 8'hF0, 9'h100, 10'd10,   1'b1},  // R4
    {7'd3,  8'h60, 7'd33, 8'h70, 8'h60, 9'h100, 10'd3,    1'b1},  // R5 equal
    {7'd3,  8'h61, 7'd33, 8'h70, 8'h60, 9'h100, 10'd1023, 1'b0},  // R5 above
    {7'd20, 8'h40, 7'd60, 8'h50, 8'hF0, 9'h040, 10'd20,   1'b0},  // R6 equal
    {7'd20, 8'h40, 7'd60, 8'h50, 8'hF0, 9'h041, 10'd20,   1'b1},  // R6 below
    {7'd0,  8'h00, 7'd63, 8'hFF, 8'hFF, 9'h100, 10'd0,    1'b1}   // R3 edges
  };

  task automatic check(input string tag, input int cpu, input int exp_id, input bit exp_req);
    int got_id;
    got_id = int'(hp_id[cpu*IDW +: IDW]);
    n_chk++;
    if (got_id != exp_id || irq_req[cpu] != exp_req) begin
      n_err++;
      $display("FAIL %s cpu%0d: id=%0d req=%0b expected id=%0d req=%0b",
               tag, cpu, got_id, irq_req[cpu], exp_id, exp_req);
    end
  endtask

  task automatic clear_all();
    dist_en = 1'b1; cpu_en = '1; irq_en = '0; irq_pend = '0;
    priv_prio = {(NCPU*NPRIV){8'h80}};
    shared_prio = {(NIRQ-NPRIV){8'h80}};
    prio_mask = {NCPU{8'hF0}};
    run_prio = {NCPU{9'h100}};
  endtask

  task automatic set_prio(input int cpu, input int id, input logic [7:0] p);
    if (id < NPRIV) priv_prio[(cpu*NPRIV + id)*PW +: PW] = p;
    else shared_prio[(id-NPRIV)*PW +: PW] = p;
  endtask

  task automatic arm(input int cpu, input int id);
    irq_en[cpu*NIRQ + id] = 1'b1;
    irq_pend[cpu*NIRQ + id] = 1'b1;
  endtask

  initial begin
    #(8*50000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: expired expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    clear_all();
    rst_n = 1'b0;
    arm(0, 4); arm(1, 4);
    @(negedge clk); @(negedge clk);
    check("R1 reset", 0, 1023, 0);
    check("R1 reset", 1, 1023, 0);
    rst_n = 1'b1;
    clear_all();
    @(negedge clk);
    check("R11 empty", 0, 1023, 0);

    for (int v = 0; v < 8; v++) begin
      logic [57:0] e;
      e = VECS[v];
      clear_all();
      set_prio(0, int'(e[57:51]), e[50:43]);
      set_prio(0, int'(e[42:36]), e[35:28]);
      arm(0, int'(e[57:51])); arm(0, int'(e[42:36]));
      prio_mask[7:0] = e[27:20];
      run_prio[8:0] = e[19:11];
      @(negedge clk);
      check($sformatf("R3-set vector %0d (R3/R4/R5/R6)", v), 0, int'(e[10:1]), e[0]);
    end

    // R2: enable without pending, pending without enable
    clear_all();
    irq_en[5] = 1'b1; irq_pend[6] = 1'b1; irq_en[NIRQ+9] = 1'b1;
    @(negedge clk);
    check("R2 half-armed", 0, 1023, 0);
    check("R2 half-armed", 1, 1023, 0);

    // R9: private priorities differ per processor, shared line common
    clear_all();
    set_prio(0, 7, 8'h10); set_prio(1, 7, 8'h90); set_prio(0, 40, 8'h50);
    arm(0, 7); arm(1, 7); arm(0, 40); arm(1, 40);
    @(negedge clk);
    check("R9 private cpu0", 0, 7, 1);
    check("R9 shared cpu1", 1, 40, 1);

    // R8: processor 1 interface off, processor 0 unaffected
    cpu_en = 2'b01;
    @(negedge clk);
    check("R8 cpu1 off", 1, 1023, 0);
    check("R8 cpu0 kept", 0, 7, 1);

    // R7: global off
    cpu_en = 2'b11; dist_en = 1'b0;
    @(negedge clk);
    check("R7 dist off", 0, 1023, 0);
    check("R7 dist off", 1, 1023, 0);

    // R10: output holds before the edge, updates after it
    dist_en = 1'b1;
    #1;
    check("R10 hold", 0, 1023, 0);
    @(negedge clk);
    check("R10 update", 0, 7, 1);

    // R11: all pending dropped
    irq_pend = '0;
    @(negedge clk);
    check("R11 drained", 0, 1023, 0);
    check("R11 drained", 1, 1023, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule